// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A cycle-accurate, synthesizable model of a pipelined synchronous static memory whose data pins are shared between reads and writes. Every control and address input is taken on the rising clock edge. At each edge the block decides whether to start an access, continue the current burst, suspend it, or deselect. Read data goes through a two-register pipeline, so it reaches the bus on the edge after the one that accepted the address. The shared data pins appear as separate `dq_i`, `dq_o` and a drive enable `dq_oe_o`. The chip-level pad turns these into a bidirectional bus.

Two address strobes can start an access, and their write timing differs. The delayed strobe always opens with a read cycle. Its write lands on the following edge, using the write controls sampled there. The immediate strobe writes on its own edge. A two-bit burst sequencer steps the low address bits in linear or interleaved order. The storage is a parameterized array of words made of four 9-bit lanes, each lane being 8 data bits plus a parity bit.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the device is deselected. `dq_oe_o` stays 0 until a read has been accepted, and cycles with neither strobe low do nothing.
- R2: A read is started by `stb_dly_ni` low (or `stb_imm_ni` low with both write controls high) with all selects active (`sel0_ni`=0, `sel1_i`=1, `sel2_ni`=0). Its data is driven after the following edge and not before, even when coming out of the deselected state.
- R3: An access opened by `stb_dly_ni` ignores the write controls and data on its first edge. The write happens on the second edge at the same address, per the write controls sampled on that edge.
- R4: `stb_imm_ni` low with `stb_dly_ni` high and all selects active writes on that same edge. If `stb_dly_ni` is also low, the cycle is a read and nothing is written.
- R5: `wr_all_ni` low writes all four lanes, whatever `wr_byte_ni` and `lane_sel_ni` are.
- R6: With `wr_all_ni` high and `wr_byte_ni` low, lane i (bits 9i+8:9i) is written only if `lane_sel_ni[i]` is 0. All other lanes keep their contents.
- R7: After any edge that performs a write, `dq_oe_o` is 0 regardless of `out_en_ni`.
- R8: A strobe seen with the selects inactive deselects the device, and `dq_oe_o` drops right after that edge, even if a read was pending. This applies to `stb_imm_ni`, and to `stb_dly_ni` only when `sel0_ni` is 0. `stb_dly_ni` low with `sel0_ni` high is ignored and treated as a continuation cycle.
- R9: In linear order (`interleave_i`=0), each continuation edge with `burst_step_ni` low moves the access to address bits [1:0] = (start + n) mod 4. The upper bits do not change.
- R10: In interleaved order (`interleave_i`=1), the n-th beat uses bits [1:0] = start XOR (n mod 4).
- R11: A continuation edge with `burst_step_ni` high repeats the current address.
- R12: `out_en_ni` high removes the drive at once, with no clock edge needed.
- R13: A new read accepted on every edge returns data on every edge, one per address, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| stb_dly_ni | input | 1 | Address strobe, write lands on the next edge (active low) |
| stb_imm_ni | input | 1 | Address strobe, write on the same edge (active low) |
| burst_step_ni | input | 1 | Advance burst address on continuation (active low) |
| sel0_ni | input | 1 | Chip select, active low; also gates `stb_dly_ni` |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| wr_all_ni | input | 1 | Write all lanes (active low) |
| wr_byte_ni | input | 1 | Lane-selective write enable (active low) |
| lane_sel_ni | input | LANES | Per-lane write select (active low) |
| out_en_ni | input | 1 | Asynchronous output enable (active low) |
| interleave_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The bench first fills the whole array with lane-specific arithmetic patterns and reads every word back with one new read per edge. This separates correct pipelining from data that is off by one address. The lane-write rule is tested by sweeping all sixteen select masks, so a misrouted or inverted lane shows up. The override of the all-lane write is tested with conflicting select values. Both strobes are tested with junk first-cycle controls and data to separate the two write latencies. Bursts run from every start offset in both orders and past the wrap point, which separates linear from interleaved stepping and stepping from holding. Deselect, write-detect, the ignored strobe and the output-enable cases each check the drive enable at the exact cycle the rule applies.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] start_i,
  input  logic          step_i,
  input  logic          interleave_i,
  output logic [CW-1:0] cur_o,
  output logic [CW-1:0] nxt_o
);
  logic [CW-1:0] start_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_inc;
    end
  end

  always_comb begin
    if (interleave_i) begin
      cur_o = start_q ^ cnt_q;
      nxt_o = start_q ^ cnt_inc;
    end else begin
      cur_o = start_q + cnt_q;
      nxt_o = start_q + cnt_inc;
    end
  end
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             stb_dly_ni,
  input  logic             stb_imm_ni,
  input  logic             burst_step_ni,
  input  logic             sel0_ni,
  input  logic             sel_all_i,
  input  logic             wr_all_ni,
  input  logic             wr_byte_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic             active_i,
  output op_e              op_o,
  output logic             load_o,
  output logic             step_o,
  output logic             desel_o,
  output logic [LANES-1:0] mask_o
);
  logic             wr_req;
  logic [LANES-1:0] wr_mask;
  logic             dly_start;
  logic             imm_start;

  assign wr_req    = !wr_all_ni || !wr_byte_ni;
  assign wr_mask   = !wr_all_ni ? '1 : (!wr_byte_ni ? ~lane_sel_ni : '0);
  assign dly_start = !stb_dly_ni && sel_all_i;
  assign imm_start = !stb_imm_ni && sel_all_i && !dly_start;
  // delayed strobe with sel0 inactive is ignored entirely
  assign desel_o   = (!stb_imm_ni || (!stb_dly_ni && !sel0_ni)) && !sel_all_i;

  always_comb begin
    op_o   = OP_NONE;
    load_o = 1'b0;
    step_o = 1'b0;
    mask_o = '0;
    if (dly_start) begin
      op_o   = OP_READ;
      load_o = 1'b1;
    end else if (imm_start) begin
      load_o = 1'b1;
      op_o   = wr_req ? OP_WRITE : OP_READ;
      mask_o = wr_mask;
    end else if (!desel_o && active_i) begin
      op_o   = wr_req ? OP_WRITE : OP_READ;
      step_o = !burst_step_ni;
      mask_o = wr_mask;
    end
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    stb_dly_ni,
  input  logic                    stb_imm_ni,
  input  logic                    burst_step_ni,
  input  logic                    sel0_ni,
  input  logic                    sel1_i,
  input  logic                    sel2_ni,
  input  logic                    wr_all_ni,
  input  logic                    wr_byte_ni,
  input  logic [LANES-1:0]        lane_sel_ni,
  input  logic                    out_en_ni,
  input  logic                    interleave_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int BW     = 2;
  localparam int HI_W   = ADDR_W - BW;

  logic             sel_all;
  op_e              op;
  logic             load;
  logic             step;
  logic             desel;
  logic [LANES-1:0] mask;
  logic [BW-1:0]    cur_lsb;
  logic [BW-1:0]    nxt_lsb;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] burst_addr;
  logic [DATA_W-1:0] arr_rdata;
  logic [LANES-1:0]  we;

  logic              active_q;
  logic [HI_W-1:0]   hi_q;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign sel_all = !sel0_ni && sel1_i && !sel2_ni;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .stb_dly_ni   (stb_dly_ni),
    .stb_imm_ni   (stb_imm_ni),
    .burst_step_ni(burst_step_ni),
    .sel0_ni      (sel0_ni),
    .sel_all_i    (sel_all),
    .wr_all_ni    (wr_all_ni),
    .wr_byte_ni   (wr_byte_ni),
    .lane_sel_ni  (lane_sel_ni),
    .active_i     (active_q),
    .op_o         (op),
    .load_o       (load),
    .step_o       (step),
    .desel_o      (desel),
    .mask_o       (mask)
  );

  sbsram_burst_seq #(.CW(BW)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .start_i     (addr_i[BW-1:0]),
    .step_i      (step),
    .interleave_i(interleave_i),
    .cur_o       (cur_lsb),
    .nxt_o       (nxt_lsb)
  );

  assign burst_addr = {hi_q, cur_lsb};
  assign acc_addr   = load ? addr_i : {hi_q, (step ? nxt_lsb : cur_lsb)};
  assign we         = (op == OP_WRITE) ? mask : '0;

  sbsram_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(acc_addr),
    .wdata_i(dq_i),
    .raddr_i(rd_addr_q),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      hi_q       <= '0;
      rd_pend_q  <= 1'b0;
      rd_addr_q  <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (load) begin
        active_q <= 1'b1;
        hi_q     <= addr_i[ADDR_W-1:BW];
      end else if (desel) begin
        active_q <= 1'b0;
      end
      rd_pend_q <= (op == OP_READ);
      if (op == OP_READ) rd_addr_q <= acc_addr;
      // a write or deselect at the output edge cancels the pending read
      rd_valid_q <= rd_pend_q && (op != OP_WRITE) && !desel;
      if (rd_pend_q) rd_data_q <= arr_rdata;
    end
  end

  assign dq_o    = rd_data_q;
  assign dq_oe_o = rd_valid_q && active_q && !out_en_ni;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_dly_ni,
  input logic              stb_imm_ni,
  input logic              burst_step_ni,
  input logic              sel0_ni,
  input logic              sel1_i,
  input logic              sel2_ni,
  input logic              wr_all_ni,
  input logic              wr_byte_ni,
  input logic              interleave_i,
  input logic              dq_oe_o,
  input logic              rd_valid_q,
  input logic              active_q,
  input logic [ADDR_W-1:0] burst_addr
);
  logic sel_all;
  logic plain_cont;
  logic wr_req;

  assign sel_all    = !sel0_ni && sel1_i && !sel2_ni;
  assign plain_cont = stb_dly_ni && stb_imm_ni && wr_all_ni && wr_byte_ni;
  assign wr_req     = !wr_all_ni || !wr_byte_ni;

  p_read_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_all && !stb_dly_ni) ##1 plain_cont |=> rd_valid_q);

  p_write_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((!stb_imm_ni && stb_dly_ni && sel_all) || (active_q && stb_dly_ni && stb_imm_ni)) && wr_req)
    |=> !dq_oe_o);

  p_deselect_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!stb_imm_ni || (!stb_dly_ni && !sel0_ni)) && !sel_all) |=> !dq_oe_o);

  p_linear_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stb_dly_ni && stb_imm_ni && !burst_step_ni && !interleave_i)
    |=> (burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1)
        && (burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])));

  p_hold_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_dly_ni && stb_imm_ni && burst_step_ni) |=> $stable(burst_addr));
endmodule

bind sync_burst_sram sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stb_dly_ni   (stb_dly_ni),
  .stb_imm_ni   (stb_imm_ni),
  .burst_step_ni(burst_step_ni),
  .sel0_ni      (sel0_ni),
  .sel1_i       (sel1_i),
  .sel2_ni      (sel2_ni),
  .wr_all_ni    (wr_all_ni),
  .wr_byte_ni   (wr_byte_ni),
  .interleave_i (interleave_i),
  .dq_oe_o      (dq_oe_o),
  .rd_valid_q   (rd_valid_q),
  .active_q     (active_q),
  .burst_addr   (burst_addr)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          stb_dly_ni = 1'b1;
  logic          stb_imm_ni = 1'b1;
  logic          burst_step_ni = 1'b1;
  logic          sel0_ni = 1'b0;
  logic          sel1_i = 1'b1;
  logic          sel2_ni = 1'b0;
  logic          wr_all_ni = 1'b1;
  logic          wr_byte_ni = 1'b1;
  logic [3:0]    lane_sel_ni = 4'hF;
  logic          out_en_ni = 1'b0;
  logic          interleave_i = 1'b0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  logic [DW-1:0] exp_mem [64];
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_burst_sram uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i),
    .stb_dly_ni(stb_dly_ni), .stb_imm_ni(stb_imm_ni), .burst_step_ni(burst_step_ni),
    .sel0_ni(sel0_ni), .sel1_i(sel1_i), .sel2_ni(sel2_ni),
    .wr_all_ni(wr_all_ni), .wr_byte_ni(wr_byte_ni), .lane_sel_ni(lane_sel_ni),
    .out_en_ni(out_en_ni), .interleave_i(interleave_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    logic [DW-1:0] p;
    for (int l = 0; l < 4; l++) p[l*9 +: 9] = 9'((a * 37 + l * 101 + salt * 59) & 511);
    return p;
  endfunction

  function automatic void model_wr(int a, logic [DW-1:0] d, logic ga, logic gb, logic [3:0] bw);
    for (int l = 0; l < 4; l++)
      if (!ga || (!gb && !bw[l])) exp_mem[a][l*9 +: 9] = d[l*9 +: 9];
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in;
    stb_dly_ni = 1; stb_imm_ni = 1; burst_step_ni = 1;
    wr_all_ni = 1; wr_byte_ni = 1; lane_sel_ni = 4'hF;
    sel0_ni = 0; sel1_i = 1; sel2_ni = 0;
  endtask

  task automatic rd_chk(int a, string tag);
    idle_in; stb_dly_ni = 0; addr_i = AW'(a);
    cyc;
    idle_in;
    cyc;
    check({tag, " drive"}, DW'(dq_oe_o), DW'(1));
    check({tag, " data"}, dq_o, exp_mem[a]);
  endtask

  task automatic wr_imm(int a, logic [DW-1:0] d, logic ga, logic gb, logic [3:0] bw);
    idle_in; stb_imm_ni = 0; addr_i = AW'(a); dq_i = d;
    wr_all_ni = ga; wr_byte_ni = gb; lane_sel_ni = bw;
    cyc;
    model_wr(a, d, ga, gb, bw);
    idle_in;
  endtask

  task automatic wr_dly(int a, logic [DW-1:0] junk, logic [DW-1:0] d,
                        logic ga, logic gb, logic [3:0] bw);
    idle_in; stb_dly_ni = 0; addr_i = AW'(a); dq_i = junk;
    wr_all_ni = 0; wr_byte_ni = 0; lane_sel_ni = 4'h0;
    cyc;
    idle_in; dq_i = d; wr_all_ni = ga; wr_byte_ni = gb; lane_sel_ni = bw;
    cyc;
    model_wr(a, d, ga, gb, bw);
    idle_in;
  endtask

  function automatic int lsb_of(int s, int n, bit il);
    return il ? (s ^ (n & 3)) : ((s + n) & 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle_in;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1: reset state, idle cycles do nothing
    check("R1 drive after reset", DW'(dq_oe_o), DW'(0));
    cyc; cyc;
    check("R1 idle stays quiet", DW'(dq_oe_o), DW'(0));

    // fill array with the all-lane write through the immediate strobe
    for (int a = 0; a < 64; a++) wr_imm(a, pat(a, 0), 1'b0, 1'b1, 4'hF);

    // R2: first cycle after deselect not driven, data one edge later
    idle_in; stb_imm_ni = 0; sel0_ni = 1; cyc;
    idle_in; stb_dly_ni = 0; addr_i = 6'd5; cyc;
    check("R2 first cycle undriven", DW'(dq_oe_o), DW'(0));
    idle_in; cyc;
    check("R2 drive", DW'(dq_oe_o), DW'(1));
    check("R2 data", dq_o, exp_mem[5]);

    // R13: one new read every edge across the whole array
    for (int a = 0; a < 64; a++) begin
      idle_in; stb_dly_ni = 0; addr_i = AW'(a);
      cyc;
      if (a > 0) check("R13 pipelined read", dq_o, exp_mem[a-1]);
    end
    idle_in; cyc;
    check("R13 pipelined read last", dq_o, exp_mem[63]);

    // R6: all sixteen lane masks
    for (int m = 0; m < 16; m++) begin
      wr_imm(20, pat(20, m + 1), 1'b1, 1'b0, 4'(m));
      rd_chk(20, "R6 lane mask");
    end

    // R5: all-lane write overrides conflicting lane selects
    wr_imm(21, pat(21, 30), 1'b0, 1'b0, 4'b0101);
    rd_chk(21, "R5 override imm");
    wr_dly(22, pat(0, 31), pat(22, 32), 1'b0, 1'b1, 4'b1111);
    rd_chk(22, "R5 override dly");

    // R3: junk first cycle ignored, second-edge controls applied
    idle_in; stb_dly_ni = 0; addr_i = 6'd30; dq_i = pat(0, 40);
    wr_all_ni = 0; wr_byte_ni = 0; lane_sel_ni = 4'h0;
    cyc;
    idle_in; dq_i = pat(30, 41); wr_byte_ni = 0; lane_sel_ni = 4'b1100;
    cyc;
    model_wr(30, pat(30, 41), 1'b1, 1'b0, 4'b1100);
    check("R7 dly write releases bus", DW'(dq_oe_o), DW'(0));
    idle_in;
    rd_chk(30, "R3 dly write");
    wr_dly(31, pat(0, 42), pat(31, 43), 1'b1, 1'b1, 4'h0);
    rd_chk(31, "R3 no controls no write");

    // R4: immediate write is single cycle, readable on next edge
    wr_imm(33, pat(33, 50), 1'b0, 1'b1, 4'hF);
    rd_chk(33, "R4 imm write");
    // R4: both strobes low -> read only
    idle_in; stb_dly_ni = 0; stb_imm_ni = 0; addr_i = 6'd34; dq_i = pat(0, 51);
    wr_all_ni = 0;
    cyc;
    idle_in; cyc;
    check("R4 both strobes read", dq_o, exp_mem[34]);
    rd_chk(34, "R4 no write");

    // R7: immediate write right after a read
    idle_in; stb_dly_ni = 0; addr_i = 6'd35; cyc;
    wr_imm(36, pat(36, 60), 1'b0, 1'b1, 4'hF);
    check("R7 imm write releases bus", DW'(dq_oe_o), DW'(0));
    rd_chk(36, "R7 data after write");

    // R8: deselect cancels a pending read
    idle_in; stb_dly_ni = 0; addr_i = 6'd37; cyc;
    idle_in; stb_imm_ni = 0; sel1_i = 0; cyc;
    check("R8 deselect release", DW'(dq_oe_o), DW'(0));
    // R8: delayed strobe with sel0 high is ignored
    idle_in; stb_dly_ni = 0; addr_i = 6'd38; cyc;
    idle_in; stb_dly_ni = 0; sel0_ni = 1; addr_i = 6'd39; cyc;
    check("R8 ignored strobe data", dq_o, exp_mem[38]);
    idle_in; cyc;
    check("R8 ignored strobe drive", DW'(dq_oe_o), DW'(1));
    check("R8 ignored strobe continue", dq_o, exp_mem[38]);

    // R12: output enable acts without a clock edge
    out_en_ni = 1; #1;
    check("R12 oe high", DW'(dq_oe_o), DW'(0));
    out_en_ni = 0; #1;
    check("R12 oe low", DW'(dq_oe_o), DW'(1));

    // R9/R10/R11: bursts from every start in both orders
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        interleave_i = il[0];
        idle_in; stb_dly_ni = 0; addr_i = AW'(40 + s); cyc;
        for (int n = 1; n <= 4; n++) begin
          idle_in; burst_step_ni = 0; cyc;
          check(il ? "R10 interleaved beat" : "R9 linear beat",
                dq_o, exp_mem[40 + lsb_of(s, n - 1, il[0])]);
        end
        idle_in; cyc;
        check(il ? "R10 wrap beat" : "R9 wrap beat", dq_o, exp_mem[40 + lsb_of(s, 4, il[0])]);
        cyc;
        check("R11 hold beat", dq_o, exp_mem[40 + lsb_of(s, 4, il[0])]);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule